// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog for a system that must be reset when its software stops servicing it. One input clock feeds a prescaler. The prescaler has a fast setting of one tick per 32 clocks and a slow setting of one tick per 32768 clocks. Its ticks drive two down-counting stages in turn. When the first stage runs out, an interrupt is raised to warn software. If software still does not restart the count, the second stage runs out. The block then drives a fixed-length system reset pulse and sets a sticky timeout flag.

Software reaches the block over a simple register bus with a word address, write data, a write strobe and combinational read data. Three registers are protected: the two stage preloads and the service register. A protected write is accepted only when it directly follows a two-word key written to the service register. A locked write is dropped without any effect. The enable register and the configuration register (tick-rate select and interrupt suppress) take plain writes.

Top module: `guard_timer`

## Requirements
- R1: The protected addresses are 2 (stage-one preload), 3 (stage-two preload) and 4 (service). A write to one of them is accepted only when the two bus writes just before it were 0x80 and then 0x86, both to address 4. A repeated 0x80 starts the key afresh. Preloads keep the low 20 bits of the written word.
- R2: A write to any other address or with any other value between the keys returns the unlock to idle. One protected write uses up the unlock. A protected write made without a valid unlock leaves the register unchanged.
- R3: Bit 0 of the configuration register (address 1) selects one tick every 32 clocks when set and one tick every 32768 clocks when clear.
- R4: Counting starts at the write that changes bit 0 of the enable register (address 0) from 0 to 1. irq_o rises P1 ticks after that write. sys_rst_o rises P1+P2 ticks after it. A preload of zero counts as one tick.
- R5: When bit 1 of the configuration register is set, irq_o stays low while the stages still run and still lead to the reset.
- R6: An unlocked write to address 4 with bit 8 set restarts stage one from its preload, clears the tick phase and drops irq_o. irq_o then rises P1 ticks after that write.
- R7: When stage two expires, sys_rst_o is high for exactly 16 clocks, timeout_flag_o is set (read back as bit 9 of address 4) and counting resumes in stage one.
- R8: The timeout flag stays set until an unlocked write to address 4 with bit 9 set clears it. A locked clear has no effect.
- R9: Writing 0 to bit 0 of the enable register stops counting at once. irq_o drops and no reset follows.
- R10: After reset every register reads 0 and irq_o, sys_rst_o and timeout_flag_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | First-stage expiry interrupt (level) |
| sys_rst_o | output | 1 | System reset pulse on second-stage expiry |
| timeout_flag_o | output | 1 | Sticky second-stage expiry flag |

## Verification
Register effects, unlocks included, show up on bus_rdata in the cycle after the write edge. The bench therefore reads back on the falling edge that follows each write. The timing results are counted in falling edges after the write edge that enables or services the timer. irq_o is due at exactly P1 times the divider, and sys_rst_o is due at (P1+P2) times the divider and stays high for 16 edges. A stop written in stage two must drop irq_o by the next falling edge. The sweep covers preloads 0 to 3 on both stages at the fast rate, one slow-rate run, a suppressed-interrupt run and the service restart, and compares each measured edge count with the product computed in the bench.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_CFG   = 3'd1,
    A_LOAD1 = 3'd2,
    A_LOAD2 = 3'd3,
    A_KICK  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic [1:0] {PH_OFF, PH_FIRST, PH_SECOND} phase_e;

  localparam int EN_BIT        = 0;
  localparam int CFG_FAST_BIT  = 0;
  localparam int CFG_NOIRQ_BIT = 1;
  localparam int KICK_BIT      = 8;
  localparam int FLAG_BIT      = 9;
endpackage

// File: rtl/gt_unlock.sv
module gt_unlock
  import guard_timer_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = 32'h80,
  parameter logic [DATA_W-1:0] KEY_B = 32'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              grant,
  output unlock_e           state
);
  unlock_e st_q, st_d;
  logic    prot;

  always_comb begin
    prot  = (addr == A_LOAD1) || (addr == A_LOAD2) || (addr == A_KICK);
    st_d  = st_q;
    grant = 1'b0;
    if (we) begin
      if (st_q == UL_OPEN && prot) begin
        grant = 1'b1;
        st_d  = UL_IDLE;
      end else if (addr == A_KICK && wdata == KEY_A) begin
        st_d = UL_HALF;
      end else if (st_q == UL_HALF && addr == A_KICK && wdata == KEY_B) begin
        st_d = UL_OPEN;
      end else begin
        st_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int FAST_DIV = 32,
  parameter int SLOW_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic fast,
  output logic tick
);
  localparam int CW = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV) : $clog2(FAST_DIV);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    tick = run && !clr && (cnt_q >= lim);
    if (!run || clr || tick) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gt_stages.sv
module gt_stages
  import guard_timer_pkg::*;
#(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          arm,
  input  logic          kick,
  input  logic          tick,
  input  logic [PW-1:0] pre1,
  input  logic [PW-1:0] pre2,
  output phase_e        phase,
  output logic          warn,
  output logic          expire
);
  phase_e        ph_q, ph_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          warn_q, warn_d;

  function automatic logic [PW-1:0] eff(input logic [PW-1:0] v);
    return (v == '0) ? PW'(1) : v;
  endfunction

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    warn_d = warn_q;
    expire = 1'b0;
    if (!run) begin
      ph_d   = PH_OFF;
      cnt_d  = '0;
      warn_d = 1'b0;
    end else if (arm || kick || ph_q == PH_OFF) begin
      ph_d   = PH_FIRST;
      cnt_d  = eff(pre1);
      warn_d = 1'b0;
    end else if (tick) begin
      if (cnt_q <= PW'(1)) begin
        if (ph_q == PH_FIRST) begin
          ph_d   = PH_SECOND;
          cnt_d  = eff(pre2);
          warn_d = 1'b1;
        end else begin
          ph_d   = PH_FIRST;
          cnt_d  = eff(pre1);
          warn_d = 1'b0;
          expire = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OFF;
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      warn_q <= warn_d;
    end
  end

  assign phase = ph_q;
  assign warn  = warn_q;
endmodule

// File: rtl/gt_rstgen.sv
module gt_rstgen #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clear,
  output logic pulse,
  output logic flag
);
  localparam int RW = $clog2(RST_LEN + 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    if (fire)               cnt_d = RW'(RST_LEN);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
    if (fire)       flag_d = 1'b1;
    else if (clear) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign pulse = (cnt_q != '0);
  assign flag  = flag_q;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int FAST_DIV  = 32,
  parameter int SLOW_DIV  = 32768,
  parameter int PRELOAD_W = 20,
  parameter int RST_LEN   = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              timeout_flag_o
);
  localparam int PW = PRELOAD_W;

  logic [SYNC_LEN-1:0] sync_q;
  logic                srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_LEN-1];

  logic          en_q, en_d, fast_q, fast_d, noirq_q, noirq_d;
  logic [PW-1:0] pre1_q, pre1_d, pre2_q, pre2_d;
  logic          grant, arm, kick, clear_flag, tick, warn, expire;
  unlock_e       ul_state;
  phase_e        phase;

  gt_unlock u_unlock (
    .clk(clk), .rst_n(srst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .grant(grant), .state(ul_state)
  );

  always_comb begin
    en_d    = en_q;
    fast_d  = fast_q;
    noirq_d = noirq_q;
    pre1_d  = pre1_q;
    pre2_d  = pre2_q;
    if (bus_we && bus_addr == A_CTRL) en_d = bus_wdata[EN_BIT];
    if (bus_we && bus_addr == A_CFG) begin
      fast_d  = bus_wdata[CFG_FAST_BIT];
      noirq_d = bus_wdata[CFG_NOIRQ_BIT];
    end
    if (grant && bus_addr == A_LOAD1) pre1_d = bus_wdata[PW-1:0];
    if (grant && bus_addr == A_LOAD2) pre2_d = bus_wdata[PW-1:0];
    arm        = en_d && !en_q;
    kick       = grant && bus_addr == A_KICK && bus_wdata[KICK_BIT];
    clear_flag = grant && bus_addr == A_KICK && bus_wdata[FLAG_BIT];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q    <= 1'b0;
      fast_q  <= 1'b0;
      noirq_q <= 1'b0;
      pre1_q  <= '0;
      pre2_q  <= '0;
    end else begin
      en_q    <= en_d;
      fast_q  <= fast_d;
      noirq_q <= noirq_d;
      pre1_q  <= pre1_d;
      pre2_q  <= pre2_d;
    end
  end

  gt_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
    .clk(clk), .rst_n(srst_n), .run(en_d), .clr(arm || kick),
    .fast(fast_q), .tick(tick)
  );

  gt_stages #(.PW(PW)) u_stages (
    .clk(clk), .rst_n(srst_n), .run(en_d), .arm(arm), .kick(kick),
    .tick(tick), .pre1(pre1_q), .pre2(pre2_q), .phase(phase),
    .warn(warn), .expire(expire)
  );

  gt_rstgen #(.RST_LEN(RST_LEN)) u_rstgen (
    .clk(clk), .rst_n(srst_n), .fire(expire), .clear(clear_flag),
    .pulse(sys_rst_o), .flag(timeout_flag_o)
  );

  assign irq_o = warn && !noirq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[EN_BIT] = en_q;
      A_CFG: begin
        bus_rdata[CFG_FAST_BIT]  = fast_q;
        bus_rdata[CFG_NOIRQ_BIT] = noirq_q;
      end
      A_LOAD1: bus_rdata[PW-1:0] = pre1_q;
      A_LOAD2: bus_rdata[PW-1:0] = pre2_q;
      A_KICK:  bus_rdata[FLAG_BIT] = timeout_flag_o;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_timer_pkg::*;
#(
  parameter int PW      = 20,
  parameter int RST_LEN = 16
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        ul_state,
  input logic              grant,
  input logic [PW-1:0]     pre1_q,
  input logic              en_q,
  input logic              clear_flag,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic              timeout_flag_o
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        run_len <= '0;
    else if (sys_rst_o) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  // R2: a locked write to the stage-one preload leaves it unchanged
  a_r2_locked_write_dropped: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == A_LOAD1 && ul_state != 2'(UL_OPEN)) |=> $stable(pre1_q));

  // R2: one unlock grants one protected write
  a_r2_unlock_consumed: assert property (@(posedge clk) disable iff (!srst_n)
    grant |=> !grant);

  // R7: the reset pulse never exceeds its length and ends at exactly that length
  a_r7_pulse_max: assert property (@(posedge clk) disable iff (!srst_n)
    run_len <= 16'(RST_LEN));
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(sys_rst_o) |-> run_len == 16'(RST_LEN));

  // R7: a reset pulse always comes with the timeout flag
  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sys_rst_o) |-> timeout_flag_o);

  // R8: the flag only falls through an unlocked clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (timeout_flag_o && !clear_flag) |=> timeout_flag_o);

  // R9: a stopped timer raises no interrupt on the next cycle
  a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (!en_q && !irq_o) |=> !irq_o);
endmodule

bind guard_timer guard_timer_chk u_chk (
  .clk(clk), .srst_n(srst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .ul_state(ul_state), .grant(grant), .pre1_q(pre1_q), .en_q(en_q),
  .clear_flag(clear_flag), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
  .timeout_flag_o(timeout_flag_o)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        we;
  logic [31:0] rdata;
  logic        irq, srst, flag;
  int          nchk = 0;
  int          nbad = 0;

  always #2 clk = ~clk;

  guard_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .irq_o(irq), .sys_rst_o(srst),
    .timeout_flag_o(flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic uwr(input logic [2:0] a, input logic [31:0] d);
    wr(3'd4, 32'h80);
    wr(3'd4, 32'h86);
    wr(a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  // program, enable, and measure edges to irq and reset, and reset length
  task automatic run_case(input int p1, input int p2, input bit fast, input bit noirq,
                          output int irq_at, output int rst_at, output int rst_len);
    int div, lim, n;
    div = fast ? 32 : 32768;
    lim = (eff(p1) + eff(p2)) * div + 100;
    wr(3'd0, 32'h0);
    wr(3'd1, {30'b0, noirq, fast});
    uwr(3'd2, p1);
    uwr(3'd3, p2);
    wr(3'd0, 32'h1);
    n = 0; irq_at = -1; rst_at = -1; rst_len = 0;
    while (rst_at < 0 && n < lim) begin
      @(negedge clk);
      n++;
      if (irq && irq_at < 0) irq_at = n;
      if (srst) rst_at = n;
    end
    if (rst_at >= 0) begin
      rst_len = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (srst) rst_len++;
        else break;
      end
    end
    wr(3'd0, 32'h0);
  endtask

  logic [31:0] v;
  int ia, ra, rl, n;
  bit seen;

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R10 reg readback", v, 32'h0);
    end
    check("R10 outputs", {29'b0, irq, srst, flag}, 32'h0);

    // R1 / R2: unlock behaviour
    wr(3'd2, 32'd5); rd(3'd2, v); check("R2 locked write", v, 32'd0);
    uwr(3'd2, 32'd5); rd(3'd2, v); check("R1 unlocked write", v, 32'd5);
    wr(3'd4, 32'h80); wr(3'd4, 32'h85); wr(3'd4, 32'h86); wr(3'd2, 32'd7);
    rd(3'd2, v); check("R2 wrong key value", v, 32'd5);
    wr(3'd4, 32'h80); wr(3'd1, 32'h0); wr(3'd4, 32'h86); wr(3'd2, 32'd7);
    rd(3'd2, v); check("R2 other address mid key", v, 32'd5);
    uwr(3'd2, 32'd9); wr(3'd2, 32'd11);
    rd(3'd2, v); check("R2 unlock consumed", v, 32'd9);
    wr(3'd4, 32'h80); wr(3'd4, 32'h80); wr(3'd4, 32'h86); wr(3'd2, 32'd13);
    rd(3'd2, v); check("R1 repeated first key", v, 32'd13);
    uwr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R1 preload width", v, 32'h000F_FFFF);
    wr(3'd1, 32'h3); rd(3'd1, v); check("R3 config readback", v, 32'h3);

    // R4 / R7: sweep of preloads at the fast rate
    for (int p1 = 0; p1 < 4; p1++) begin
      for (int p2 = 0; p2 < 4; p2++) begin
        run_case(p1, p2, 1'b1, 1'b0, ia, ra, rl);
        check("R4 irq edge", ia, eff(p1) * 32);
        check("R4 reset edge", ra, (eff(p1) + eff(p2)) * 32);
        check("R7 reset length", rl, 16);
      end
    end

    // R5: suppressed interrupt, reset still follows
    run_case(2, 1, 1'b1, 1'b1, ia, ra, rl);
    check("R5 irq suppressed", ia, -1);
    check("R5 reset still due", ra, 96);

    // R7 / R8: sticky flag and its clear
    check("R7 flag port", {31'b0, flag}, 32'h1);
    rd(3'd4, v); check("R7 flag readback", v, 32'h200);
    wr(3'd4, 32'h200); rd(3'd4, v); check("R8 locked clear", v, 32'h200);
    uwr(3'd4, 32'h200); rd(3'd4, v); check("R8 unlocked clear", v, 32'h0);

    // R6: service restart from stage two
    wr(3'd1, 32'h1); uwr(3'd2, 32'd3); uwr(3'd3, 32'd3); wr(3'd0, 32'h1);
    repeat (100) @(negedge clk);
    check("R6 irq before service", {31'b0, irq}, 32'h1);
    uwr(3'd4, 32'h100);
    check("R6 irq dropped", {31'b0, irq}, 32'h0);
    n = 0; seen = 1'b0;
    while (!seen && n < 200) begin
      @(negedge clk); n++;
      if (irq) seen = 1'b1;
    end
    check("R6 irq edge after service", n, 96);
    check("R6 flag untouched", {31'b0, flag}, 32'h0);

    // R9: stop during stage two
    wr(3'd0, 32'h0); uwr(3'd2, 32'd1); uwr(3'd3, 32'd2); wr(3'd0, 32'h1);
    repeat (40) @(negedge clk);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    check("R9 irq dropped", {31'b0, irq}, 32'h0);
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (srst || irq) seen = 1'b1;
    end
    check("R9 no reset after stop", {31'b0, seen}, 32'h0);

    // R3: slow rate
    run_case(1, 1, 1'b0, 1'b0, ia, ra, rl);
    check("R3 slow irq edge", ia, 32768);
    check("R3 slow reset edge", ra, 65536);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    nchk++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule